// File: doc/BRIEF.md
# Converter Result Queue with Fill-Level Interrupt

This block sits between a conversion engine and a 32-bit register bus. The engine presents each finished sample with a one-cycle valid strobe, and the block queues it in a small first-in first-out store. A bus master takes results out by reading one fixed result address. Each such read returns the oldest sample and removes it from the queue. A programmable threshold drives a level interrupt, so software can drain a batch of results in one service routine.

Software controls the block through a handful of word registers. A control word holds the converter enable, a software reset that stays set until software clears it, and a one-shot queue flush. A queue control word holds the live fill count next to a threshold field. The threshold field is written as the wanted level minus one. A status word holds a sticky overflow flag, and an interrupt-enable word gates the interrupt output.

Top module: `adc_result_fifo`

## Requirements
- R1: The queue holds up to DEPTH (16) samples and returns them oldest first. Its current fill count reads back in bits 4:0 of the queue control word at offset 0x30.
- R2: An aligned read of offset 0x300 returns the oldest sample in bits 18:3, with every other bit zero, and removes that sample in the same cycle.
- R3: A read of offset 0x300 while the queue is empty returns zero and leaves the fill count unchanged.
- R4: Bits 20:16 of offset 0x30 hold the threshold field T, which is writable and reads back. The interrupt output is high while any of bits 1:0 of offset 0x18 is set and the fill count exceeds T, so T=0 means one entry. It drops once reads bring the count to T or below.
- R5: A sample that arrives while the queue is full and no pop happens in the same cycle is dropped. It sets bit 0 of the status word at offset 0x14, which stays set until software writes 1 to that bit.
- R6: Writing 1 to bit 8 of the control word at offset 0x10 empties the queue by the next clock. That bit always reads back as 0.
- R7: While bit 1 of the control word is 1, the queue is held empty, arriving samples are discarded and the overflow flag is cleared. The bit reads back as written until software writes 0.
- R8: Bit 0 of the control word drives `conv_enable`. Samples that arrive while it is 0 are ignored.
- R9: A bus access whose address bits 1:0 are not zero writes nothing, reads zero and pops nothing. Offsets that map to no register read zero.
- R10: After reset every register reads zero, the queue is empty and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of 0x300 pops) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| conv_valid | input | 1 | Sample-ready strobe from the converter |
| conv_data | input | 16 | Sample value |
| conv_enable | output | 1 | Converter enable from control bit 0 |
| wm_irq | output | 1 | Level interrupt on the fill threshold |

## Verification
On every cycle, the assertions check four things. The fill count never exceeds the depth. A read of an empty queue returns zero. A flush request leaves the queue empty. A sample that arrives while the queue is full leaves the count at the depth and the overflow flag set. They also check that the interrupt never stands while the queue is empty. Other properties can only be shown by the bench's scenarios: that samples come back in arrival order with the right bit placement, that the interrupt falls at exactly the programmed threshold, that misaligned accesses have no effect, and that the enable and software reset gate incoming samples.

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
  parameter int DEPTH    = 16,
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                conv_valid,
  input  logic [SAMPLE_W-1:0] conv_data,
  output logic                conv_enable,
  output logic                wm_irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int SHIFT = 3;
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] OFS_IEN  = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] OFS_QCTL = ADDR_W'(12'h030);
  localparam logic [ADDR_W-1:0] OFS_RES  = ADDR_W'(12'h300);

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    fill_cnt;
  logic [4:0]          wm_q;
  logic [1:0]          ien_q;
  logic                en_q, srst_q, ovf_q;

  wire aligned = (bus_addr[1:0] == 2'b00);
  wire wr_ctrl = bus_wr && aligned && bus_addr == OFS_CTRL;
  wire wr_stat = bus_wr && aligned && bus_addr == OFS_STAT;
  wire wr_ien  = bus_wr && aligned && bus_addr == OFS_IEN;
  wire wr_qctl = bus_wr && aligned && bus_addr == OFS_QCTL;
  wire rd_res  = bus_rd && aligned && bus_addr == OFS_RES;

  wire flush   = srst_q || (wr_ctrl && (bus_wdata[8] || bus_wdata[1]));
  wire empty   = (fill_cnt == '0);
  wire full    = (fill_cnt == CNT_W'(DEPTH));
  wire pop     = rd_res && !empty && !flush;
  wire arrive  = conv_valid && en_q && !flush;
  wire push    = arrive && (!full || pop);
  wire dropped = arrive && full && !pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_cnt <= '0;
    end else if (flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_cnt <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      fill_cnt <= fill_cnt + 1'b1;
      else if (pop && !push) fill_cnt <= fill_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
      ien_q  <= '0;
      wm_q   <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[0];
        srst_q <= bus_wdata[1];
      end
      if (wr_ien)  ien_q <= bus_wdata[1:0];
      if (wr_qctl) wm_q  <= bus_wdata[20:16];
      if (srst_q)                     ovf_q <= 1'b0;
      else if (dropped)               ovf_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      unique case (bus_addr)
        OFS_CTRL: bus_rdata = {30'd0, srst_q, en_q};
        OFS_STAT: bus_rdata = {31'd0, ovf_q};
        OFS_IEN:  bus_rdata = {30'd0, ien_q};
        OFS_QCTL: bus_rdata = {11'd0, wm_q, 11'd0, 5'(fill_cnt)};
        OFS_RES:  if (!empty) bus_rdata = 32'(mem[rd_ptr]) << SHIFT;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign conv_enable = en_q;
  assign wm_irq      = (|ien_q) && (5'(fill_cnt) > wm_q);
endmodule

module adc_result_fifo_chk #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              conv_valid,
  input logic              conv_enable,
  input logic              wm_irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf
);
  wire res_rd = bus_rd && bus_addr == ADDR_W'(12'h300);
  wire clr_wr = bus_wr && bus_addr == ADDR_W'(12'h010) && (bus_wdata[8] || bus_wdata[1]);

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R1
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && cnt == '0) |-> bus_rdata == '0); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH) && conv_valid && conv_enable && !res_rd && !bus_wr)
      |=> (cnt == CNT_W'(DEPTH) && ovf)); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> cnt == '0); // R6
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wm_irq |-> cnt != '0); // R4
endmodule

bind adc_result_fifo adc_result_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_valid(conv_valid),
  .conv_enable(conv_enable), .wm_irq(wm_irq), .cnt(fill_cnt), .ovf(ovf_q)
);

// File: tb/adc_result_fifo_test.sv
module adc_result_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        conv_valid = 1'b0;
  logic [15:0] conv_data = '0;
  logic        conv_enable, wm_irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  adc_result_fifo uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_valid(conv_valid),
    .conv_data(conv_data), .conv_enable(conv_enable), .wm_irq(wm_irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk); conv_data = v; conv_valid = 1'b1;
    @(negedge clk); conv_valid = 1'b0;
  endtask

  function automatic logic [31:0] cnt_of(input logic [31:0] q);
    return {27'd0, q[4:0]};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h010, d); check("R10 ctrl", d, 0);
    rd(12'h014, d); check("R10 status", d, 0);
    rd(12'h018, d); check("R10 ien", d, 0);
    rd(12'h030, d); check("R10 qctl", d, 0);
    check("R10 irq", {31'd0, wm_irq}, 0);
    check("R10 enable", {31'd0, conv_enable}, 0);
  endtask

  task automatic t_enable_gate();
    logic [31:0] d;
    push(16'h1234);
    rd(12'h030, d); check("R8 ignored while off", cnt_of(d), 0);
    wr(12'h010, 32'h1);
    check("R8 enable pin", {31'd0, conv_enable}, 1);
  endtask

  task automatic t_order_overflow();
    logic [31:0] d;
    for (int i = 1; i <= 17; i++) push(16'(i * 16'h0101));
    rd(12'h030, d); check("R1 full count", cnt_of(d), 16);
    rd(12'h014, d); check("R5 overflow set", d, 1);
    for (int i = 1; i <= 16; i++) begin
      rd(12'h300, d); check("R1 R2 order and field", d, 32'(i * 16'h0101) << 3);
    end
    rd(12'h030, d); check("R2 drained", cnt_of(d), 0);
    rd(12'h014, d); check("R5 sticky", d, 1);
    wr(12'h014, 32'h1);
    rd(12'h014, d); check("R5 w1c", d, 0);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    rd(12'h300, d); check("R3 empty data", d, 0);
    rd(12'h030, d); check("R3 count kept", cnt_of(d), 0);
    push(16'hffff);
    rd(12'h300, d); check("R2 top bits", d, 32'h0007fff8);
  endtask

  task automatic t_watermark();
    logic [31:0] d;
    wr(12'h030, 32'h0002_0000);
    rd(12'h030, d); check("R4 threshold readback", d, 32'h0002_0000);
    wr(12'h018, 32'h1);
    push(16'h11); push(16'h22);
    check("R4 irq at threshold", {31'd0, wm_irq}, 0);
    push(16'h33);
    check("R4 irq above threshold", {31'd0, wm_irq}, 1);
    wr(12'h018, 32'h0);
    check("R4 irq gated", {31'd0, wm_irq}, 0);
    wr(12'h018, 32'h2);
    check("R4 irq other enable bit", {31'd0, wm_irq}, 1);
    rd(12'h300, d);
    check("R4 irq falls", {31'd0, wm_irq}, 0);
    wr(12'h030, 32'h0);
    check("R4 level one", {31'd0, wm_irq}, 1);
  endtask

  task automatic t_fifo_flush();
    logic [31:0] d;
    wr(12'h010, 32'h101);
    rd(12'h030, d); check("R6 flushed", cnt_of(d), 0);
    check("R6 irq low", {31'd0, wm_irq}, 0);
    rd(12'h010, d); check("R6 self clear", d, 1);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    push(16'h5); push(16'h6);
    wr(12'h010, 32'h3);
    rd(12'h030, d); check("R7 cleared", cnt_of(d), 0);
    push(16'h7);
    rd(12'h030, d); check("R7 held", cnt_of(d), 0);
    rd(12'h010, d); check("R7 stays set", d, 3);
    wr(12'h010, 32'h1);
    push(16'h8);
    rd(12'h300, d); check("R7 released", d, 32'h40);
  endtask

  task automatic t_misaligned();
    logic [31:0] d;
    wr(12'h032, 32'h001f_0000);
    rd(12'h030, d); check("R9 write ignored", d, 0);
    push(16'h9);
    rd(12'h302, d); check("R9 read zero", d, 0);
    rd(12'h030, d); check("R9 no pop", cnt_of(d), 1);
    rd(12'h0ffc, d); check("R9 unmapped", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_gate();
    t_order_overflow();
    t_empty_read();
    t_watermark();
    t_fifo_flush();
    t_soft_reset();
    t_misaligned();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule